// File: doc/BRIEF.md
# Timeout-Then-Window Watchdog

This block supervises a microcontroller that proves it is alive by pulling a trigger line low. After any reset, and whenever the watchdog is switched on, it runs a plain timeout: one service anywhere in that period is enough. The first accepted service moves it into window mode. Each window period starts with a closed part, where a service counts as a fault, and continues with an open part, where a service must arrive. Every accepted service restarts the current period at once.

A missed service, an early service, a persisting supply undervoltage, a power-on indication or a level-2 overtemperature indication drives an active-low reset toward the microcontroller. The reset lasts a fixed number of ticks. While it is low, trigger activity is ignored and the timers stay cleared. When the reset releases, the watchdog starts again in timeout mode. All periods count ticks of an internal prescaler, `PRESCALE` clock cycles per tick. The values below assume `PRESCALE` = 1.

Top module: `wdog_tw`

## Requirements
- R1: After `rst_n` is released, `mcu_rst_n` is high. `wd_mode` uses the code 0 for off, 1 for timeout, 2 for the closed window and 3 for the open window, and it shows 0 while `wd_on` is low.
- R2: A service needs a falling edge on `trig` after two-stage synchronisation, followed by a low level that lasts at least `MIN_LOW` ticks (`MIN_LOW` >= 2). It takes effect on the (`MIN_LOW`+1)-th clock edge that samples `trig` low. A low pulse shorter than `MIN_LOW` has no effect.
- R3: In timeout mode, a service on any tick up to and including the `T_TMO`-th moves the watchdog to the closed window. With no service, reset asserts on the `T_TMO`-th tick after the period started.
- R4: The closed window lasts `T_CLOSED` ticks. A service that takes effect on any of those ticks, including the last, is a failure and asserts reset.
- R5: The open window follows for `T_OPEN` ticks. A service in it, including on its last tick, restarts the closed window. With no service, reset asserts on the last tick.
- R6: A failure holds `mcu_rst_n` low for exactly `T_RST` ticks (`T_RST` >= 2). While the reset is low and `wd_on` is high, `wd_mode` shows timeout, and the timeout period starts fresh when reset releases.
- R7: While `mcu_rst_n` is low, trigger edges are ignored and no timer advances.
- R8: While `wd_on` is low, `wd_mode` is 0, no failure occurs and the trigger is ignored. A rise of `wd_on` starts a fresh timeout period.
- R9: `uv_flag` asserts reset only once it has been high on `UV_FILT` consecutive ticks. A shorter high has no effect. Once tripped, reset stays low while the flag stays high and for `T_RST` ticks after it falls.
- R10: `pwr_on` or `hot_flag` high holds reset low, and reset stays low for `T_RST` ticks after the last tick on which either was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| wd_on | input | 1 | Watchdog enable |
| trig | input | 1 | Service trigger from the microcontroller (falling edge) |
| uv_flag | input | 1 | Raw supply undervoltage indication |
| hot_flag | input | 1 | Thermal shutdown level 2 indication |
| pwr_on | input | 1 | Power-on indication |
| mcu_rst_n | output | 1 | Reset to the microcontroller, active low |
| wd_mode | output | 2 | Mode: 0 off, 1 timeout, 2 closed, 3 open |

## Verification
The bench places services on the exact boundary ticks. It uses the last tick of the timeout and of the open window, where a design that lets expiry beat the service would fail a valid service. It uses the last closed tick and the first open tick, where an off-by-one would either let an early service through or punish a correct one. It sends a trigger pulse one tick short of `MIN_LOW` inside the closed window, which a design without a width filter would turn into a false failure. It also sends a trigger during the reset pulse and toggles the enable. A design that does not hold its timers there would leave the reset pulse in window mode, or fail early after the release or the enable. The undervoltage filter is driven one tick short of its limit and then exactly to it.

// File: rtl/wdog_tw.sv
module wdog_tw #(
  parameter int PRESCALE = 1,
  parameter int T_TMO    = 65,
  parameter int T_CLOSED = 6,
  parameter int T_OPEN   = 100,
  parameter int T_RST    = 8,
  parameter int MIN_LOW  = 6,
  parameter int UV_FILT  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_on,
  input  logic       trig,
  input  logic       uv_flag,
  input  logic       hot_flag,
  input  logic       pwr_on,
  output logic       mcu_rst_n,
  output logic [1:0] wd_mode
);
  localparam int PW   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TMAX = (T_TMO > T_OPEN) ? ((T_TMO > T_CLOSED) ? T_TMO : T_CLOSED)
                                         : ((T_OPEN > T_CLOSED) ? T_OPEN : T_CLOSED);
  localparam int CW = $clog2(TMAX + 1);
  localparam int RW = $clog2(T_RST + 1);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam int UW = $clog2(UV_FILT + 1);
  localparam logic [1:0] M_OFF = 2'd0, M_TMO = 2'd1, M_CLS = 2'd2, M_OPN = 2'd3;

  logic [PW-1:0] pre_q;
  logic [2:0]    sy;
  logic          armed;
  logic [LW-1:0] lowcnt;
  logic [1:0]    phase;
  logic [CW-1:0] cnt, lim;
  logic [UW-1:0] uvcnt;
  logic [RW-1:0] rcnt;

  wire tick   = (pre_q == PW'(PRESCALE - 1));
  wire in_rst = (rcnt != '0);
  wire run    = wd_on & ~in_rst;
  wire fall   = sy[2] & ~sy[1];
  wire svc    = run & armed & ~sy[1] & tick & (lowcnt == LW'(MIN_LOW - 1));
  wire last   = (cnt == lim);
  wire fail   = run & ((phase == M_CLS) ? svc : (tick & last & ~svc));
  wire uv_trip = uv_flag & (uvcnt == UW'(UV_FILT - 1));
  wire ev     = fail | pwr_on | hot_flag | uv_trip;

  always_comb begin
    case (phase)
      M_CLS:   lim = CW'(T_CLOSED - 1);
      M_OPN:   lim = CW'(T_OPEN - 1);
      default: lim = CW'(T_TMO - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= 3'b111;
    else        sy <= {sy[1:0], trig};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      lowcnt <= '0;
    end else if (!run) begin
      armed  <= 1'b0;
      lowcnt <= '0;
    end else if (fall) begin
      armed  <= 1'b1;
      lowcnt <= tick ? LW'(1) : '0;
    end else if (svc || sy[1]) begin
      armed  <= 1'b0;
    end else if (armed && tick) begin
      lowcnt <= lowcnt + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= M_TMO;
      cnt   <= '0;
    end else if (!run || fail) begin
      phase <= M_TMO;
      cnt   <= '0;
    end else if (svc) begin
      phase <= M_CLS;
      cnt   <= '0;
    end else if (tick) begin
      if (last) begin
        phase <= M_OPN;
        cnt   <= '0;
      end else begin
        cnt   <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                uvcnt <= '0;
    else if (!uv_flag)         uvcnt <= '0;
    else if (tick && !uv_trip) uvcnt <= uvcnt + UW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rcnt <= '0;
    else if (ev)               rcnt <= RW'(T_RST);
    else if (in_rst && tick)   rcnt <= rcnt - RW'(1);
  end

  assign mcu_rst_n = ~in_rst;
  assign wd_mode   = wd_on ? phase : M_OFF;
endmodule

// File: rtl/wdog_tw_chk.sv
module wdog_tw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wd_on,
  input logic       mcu_rst_n,
  input logic [1:0] wd_mode
);
  // R6
  pulse_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mcu_rst_n) |=> !mcu_rst_n);
  // R6
  release_in_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mcu_rst_n) && wd_on) |-> (wd_mode == 2'd1));
  // R3
  tmo_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_mode == 2'd1) |=> (wd_mode != 2'd3));
  // R4
  closed_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_mode == 2'd2) |=> (wd_mode != 2'd1 || !mcu_rst_n));
  // R5
  open_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_mode == 2'd3) |=> (wd_mode != 2'd1 || !mcu_rst_n));
  // R8
  off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_mode == 2'd0) |=> (wd_mode == 2'd0 || wd_mode == 2'd1));
endmodule

bind wdog_tw wdog_tw_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wd_on(wd_on), .mcu_rst_n(mcu_rst_n), .wd_mode(wd_mode)
);

// File: tb/wdog_tw_tb_top.sv
module wdog_tw_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0, wd_on = 1'b0, trig = 1'b1;
  logic uv_flag = 1'b0, hot_flag = 1'b0, pwr_on = 1'b0;
  logic mcu_rst_n;
  logic [1:0] wd_mode;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  wdog_tw #(.PRESCALE(1), .T_TMO(40), .T_CLOSED(12), .T_OPEN(30), .T_RST(8),
            .MIN_LOW(3), .UV_FILT(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .wd_on(wd_on), .trig(trig), .uv_flag(uv_flag),
    .hot_flag(hot_flag), .pwr_on(pwr_on), .mcu_rst_n(mcu_rst_n), .wd_mode(wd_mode));

  localparam int NV = 7;
  localparam int VD [NV] = '{20, 13, 42, 25, 12, 40, 14};
  localparam int VW [NV] = '{5, 3, 5, 5, 5, 5, 5};
  localparam logic [1:0] VM [NV] = '{2'd2, 2'd2, 2'd2, 2'd2, 2'd1, 2'd2, 2'd2};
  localparam logic VR [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam string VQ [NV] = '{"R3", "R5", "R5", "R5", "R4", "R3", "R2"};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] em, input logic er);
    n_chk++;
    if (wd_mode !== em || mcu_rst_n !== er) begin
      n_bad++;
      $display("FAIL %s: mode=%0d rst_n=%0b expected mode=%0d rst_n=%0b",
               req, wd_mode, mcu_rst_n, em, er);
    end
  endtask

  // service whose effect lands d edges after the current period start
  task automatic service_at(input int d, input int w);
    step(d - 5);
    trig = 1'b0;
    step(w);
    trig = 1'b1;
    step(5 - w);
  endtask

  task automatic pulse_tail(input string req);
    step(7);
    chk(req, 2'd1, 1'b0);
    step(1);
    chk(req, 2'd1, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    chk("R1", 2'd0, 1'b1);
    step(2);
    chk("R1", 2'd0, 1'b1);
    wd_on = 1'b1;

    for (int i = 0; i < NV; i++) begin
      service_at(VD[i], VW[i]);
      chk(VQ[i], VM[i], VR[i]);
      if (!VR[i]) pulse_tail("R6");
    end

    // R5 open window runs out
    step(41); chk("R5", 2'd3, 1'b1);
    step(1);  chk("R5", 2'd1, 1'b0);
    pulse_tail("R6");

    // R3 timeout runs out
    step(39); chk("R3", 2'd1, 1'b1);
    step(1);  chk("R3", 2'd1, 1'b0);
    pulse_tail("R6");

    // R2 short pulse in closed window ignored
    service_at(15, 5); chk("R2", 2'd2, 1'b1);
    step(1); trig = 1'b0; step(2); trig = 1'b1;
    step(6); chk("R2", 2'd2, 1'b1);
    step(3); chk("R2", 2'd3, 1'b1);
    service_at(10, 5); chk("R5", 2'd2, 1'b1);

    // R7 trigger during reset pulse ignored, timers held
    service_at(12, 5); chk("R4", 2'd1, 1'b0);
    step(2); trig = 1'b0; step(4); trig = 1'b1;
    step(1); chk("R7", 2'd1, 1'b0);
    step(1); chk("R7", 2'd1, 1'b1);
    step(39); chk("R7", 2'd1, 1'b1);
    step(1);  chk("R7", 2'd1, 1'b0);
    step(8);

    // R8 enable off and back on
    step(20); wd_on = 1'b0;
    step(1); chk("R8", 2'd0, 1'b1);
    trig = 1'b0; step(5); trig = 1'b1;
    step(55); chk("R8", 2'd0, 1'b1);
    wd_on = 1'b1;
    step(39); chk("R8", 2'd1, 1'b1);
    step(1);  chk("R8", 2'd1, 1'b0);
    step(8);

    // R9 undervoltage filter
    uv_flag = 1'b1; step(9); uv_flag = 1'b0;
    step(2); chk("R9", 2'd1, 1'b1);
    uv_flag = 1'b1; step(10); chk("R9", 2'd1, 1'b0);
    step(5); chk("R9", 2'd1, 1'b0);
    uv_flag = 1'b0;
    pulse_tail("R9");

    // R10 power-on and thermal level 2
    pwr_on = 1'b1; step(20); chk("R10", 2'd1, 1'b0);
    pwr_on = 1'b0;
    pulse_tail("R10");
    hot_flag = 1'b1; step(1); hot_flag = 1'b0;
    pulse_tail("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule